// File: doc/BRIEF.md
# SMBus Slave Receive Engine with Packet Error Check

This block is the receive half of an SMBus slave. A separate bus front end samples SCL and SDA. It passes in one-cycle strobes for start and stop conditions. It also passes in one strobe per data bit for the eight bits of each byte, most significant bit first. The acknowledge slot is not strobed. For each byte, the engine returns an acknowledge decision, which the front end drives onto SDA in the ninth clock.

After a start, the first byte is the address byte. The engine accepts it when the address matches one of the following and the direction bit is a write:
- its own 7-bit address;
- when enabled, the reserved alert-response address;
- when enabled, the reserved host-header address.

Accepted data bytes are presented on a byte output with a one-cycle valid strobe. An optional counter counts them.

A CRC-8 runs over every bit on the bus, whether or not checking is enabled, so a transfer made of several linked segments keeps a correct running value. When checking is on for a transfer, one byte position is treated as the check byte. That byte is acknowledged only if it agrees with the running CRC. A mismatch raises a sticky error flag.

Top module: `smbus_pec_rx`

## Requirements
- R1: After a start, the address byte is ACKed when its upper seven bits equal `ownAddr` and its bit 0 (direction) is 0. A wrong address or a direction bit of 1 is NACKed, and every later byte up to the next start produces no `ackValid` pulse and no `rxValid` pulse.
- R2: Address 7'h0C is accepted only while `alertMatchEn` is 1. Address 7'h08 is accepted only while `hostMatchEn` is 1. Each enable works independently of the other and of `ownAddr`.
- R3: `ackValid` is high for exactly the one clock that follows the strobe of the eighth bit of a byte. `ackBit` is 1 for ACK and 0 for NACK.
- R4: Every data byte of an accepted transfer that is not a check byte is ACKed. It appears on `rxData` with `rxValid` high for one clock, in the same cycle as its `ackValid` pulse.
- R5: While `pecEn` is 1, the data byte with zero-based index `dataLen` after the address byte is the check byte. It never asserts `rxValid`. Bytes after it, up to the next start, get no `ackValid` pulse.
- R6: The check byte is ACKed exactly when it equals the CRC-8 of all bits since the session began. The CRC uses polynomial 0x07, initial value 0x00, MSB first, with no final XOR.
- R7: A check byte that disagrees is NACKed and sets `pecErr`. `pecErr` stays set until `pecErrClr` is high with no new mismatch in the same cycle.
- R8: The CRC absorbs every bit strobed between a start and a stop. This holds when `pecEn` is 0 and when the address did not match.
- R9: The CRC returns to 0x00 on a start that follows a stop or reset. A repeated start does not clear it.
- R10: `byteCount` returns to 0 on a start that follows a stop or reset, and is not cleared by a repeated start. It adds one for each data byte delivered while `countUpEn` is 1, and otherwise holds.
- R11: Out of reset, `rxData`, `rxValid`, `ackValid`, `ackBit`, `byteCount` and `pecErr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busStart | input | 1 | One-cycle strobe for a start or repeated start |
| busStop | input | 1 | One-cycle strobe for a stop condition |
| bitValid | input | 1 | One-cycle strobe that carries one sampled data bit |
| bitData | input | 1 | Value of the strobed bit |
| ownAddr | input | 7 | Own slave address |
| alertMatchEn | input | 1 | Accept the alert-response address 7'h0C |
| hostMatchEn | input | 1 | Accept the host-header address 7'h08 |
| pecEn | input | 1 | Check-byte handling for the current transfer |
| dataLen | input | CNT_W | Index of the check byte among the data bytes |
| countUpEn | input | 1 | Count delivered data bytes |
| pecErrClr | input | 1 | Clears the sticky check error |
| rxData | output | 8 | Received data byte |
| rxValid | output | 1 | One-cycle strobe for `rxData` |
| ackValid | output | 1 | One-cycle strobe: an acknowledge decision is ready |
| ackBit | output | 1 | 1 = ACK, 0 = NACK |
| byteCount | output | CNT_W | Delivered data byte count |
| pecErr | output | 1 | Sticky check-byte mismatch flag |

## Verification
The embedded assertions check the following on every cycle:
- a delivered byte always coincides with an ACK decision;
- a new check error always coincides with a NACK;
- no decision appears while the engine is idle or skipping;
- the CRC holds between bit strobes and is zero after a session start;
- the counter only steps by one or returns to zero.

Only the bench's scenarios can show that the CRC value itself is right. This covers a good and a corrupted check byte, and a linked transfer in which the first segment ran with checking off. The scenarios also show that the session clear happens on a start after a stop and not on a repeated start, and that the reserved addresses follow their enables.

// File: rtl/smbus_rx_pkg.sv
package smbus_rx_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam logic [BYTE_W-1:0] CRC_POLY = 8'h07;
  localparam logic [ADDR_W-1:0] ALERT_ADDR = 7'h0C;
  localparam logic [ADDR_W-1:0] HOST_ADDR = 7'h08;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_SKIP} rx_state_t;

  // control -> datapath strobes
  typedef struct packed {
    logic bitTake;       // a bus bit is absorbed this cycle
    logic frameStart;    // any start: realign byte boundary
    logic sessionClear;  // start after stop: clear CRC and counter
    logic emitData;      // present byteNext as a data byte
    logic cntInc;        // step the byte counter
  } rx_strobe_t;

  function automatic logic [BYTE_W-1:0] crcStep(input logic [BYTE_W-1:0] cur, input logic b);
    logic fb;
    fb = cur[BYTE_W-1] ^ b;
    return {cur[BYTE_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/smbus_rx_dp.sv
module smbus_rx_dp
  import smbus_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rx_strobe_t        stb,
  input  logic              bitData,
  output logic              lastBit,
  output logic [BYTE_W-1:0] byteNext,
  output logic [BYTE_W-1:0] crcNext,
  output logic [BYTE_W-1:0] rxData,
  output logic              rxValid,
  output logic [CNT_W-1:0]  byteCount
);

  localparam int BIT_CW = $clog2(BYTE_W);

  logic [BIT_CW-1:0] bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic [BYTE_W-1:0] crcReg;

  assign lastBit  = (bitCnt == BIT_CW'(BYTE_W - 1));
  assign byteNext = {shiftReg[BYTE_W-2:0], bitData};
  assign crcNext  = crcStep(crcReg, bitData);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (stb.frameStart) begin
      bitCnt <= '0;
    end else if (stb.bitTake) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= byteNext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                crcReg <= '0;
    else if (stb.sessionClear) crcReg <= '0;
    else if (stb.bitTake)      crcReg <= crcNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxData    <= '0;
      rxValid   <= 1'b0;
      byteCount <= '0;
    end else begin
      rxValid <= stb.emitData;
      if (stb.emitData) rxData <= byteNext;
      if (stb.sessionClear)  byteCount <= '0;
      else if (stb.cntInc)   byteCount <= byteCount + 1'b1;
    end
  end

  // R8: CRC moves only on an absorbed bit or a session clear
  assert_crc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb.bitTake && !stb.sessionClear) |=> $stable(crcReg));

  // R9: session clear leaves a zero CRC
  assert_crc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stb.sessionClear |=> (crcReg == '0));

  // R10: counter steps by one or returns to zero
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byteCount) |-> ((byteCount == $past(byteCount) + 1'b1) || (byteCount == '0)));

endmodule

// File: rtl/smbus_rx_ctrl.sv
module smbus_rx_ctrl
  import smbus_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busStart,
  input  logic              busStop,
  input  logic              bitValid,
  input  logic              lastBit,
  input  logic [BYTE_W-1:0] byteNext,
  input  logic [BYTE_W-1:0] crcNext,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              alertMatchEn,
  input  logic              hostMatchEn,
  input  logic              pecEn,
  input  logic [CNT_W-1:0]  dataLen,
  input  logic              countUpEn,
  input  logic              pecErrClr,
  output rx_strobe_t        stb,
  output logic              ackValid,
  output logic              ackBit,
  output logic              pecErr
);

  rx_state_t        state, stateNext;
  logic             busActive, afterStop;
  logic [CNT_W-1:0] dataIdx, idxNext;
  logic             bitTake, byteDone, addrHit;
  logic             ackFire, ackGood, emitData, cntInc, pecFail;
  logic [ADDR_W-1:0] rxAddr;

  assign bitTake  = bitValid && busActive && !busStart && !busStop;
  assign byteDone = bitTake && lastBit;
  assign rxAddr   = byteNext[BYTE_W-1:1];
  assign addrHit  = !byteNext[0] &&
                    ((rxAddr == ownAddr) ||
                     (alertMatchEn && rxAddr == ALERT_ADDR) ||
                     (hostMatchEn  && rxAddr == HOST_ADDR));

  always_comb begin
    ackFire   = 1'b0;
    ackGood   = 1'b0;
    emitData  = 1'b0;
    cntInc    = 1'b0;
    pecFail   = 1'b0;
    stateNext = state;
    idxNext   = dataIdx;
    if (byteDone) begin
      case (state)
        ST_ADDR: begin
          ackFire   = 1'b1;
          ackGood   = addrHit;
          stateNext = addrHit ? ST_DATA : ST_SKIP;
          idxNext   = '0;
        end
        ST_DATA: begin
          ackFire = 1'b1;
          if (pecEn && dataIdx == dataLen) begin
            // residue of message plus its CRC is zero when they agree
            ackGood   = (crcNext == '0);
            pecFail   = !ackGood;
            stateNext = ST_SKIP;
          end else begin
            ackGood  = 1'b1;
            emitData = 1'b1;
            cntInc   = countUpEn;
            idxNext  = dataIdx + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign stb = '{bitTake:      bitTake,
                 frameStart:   busStart,
                 sessionClear: busStart && afterStop,
                 emitData:     emitData,
                 cntInc:       cntInc};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      busActive <= 1'b0;
      afterStop <= 1'b1;
      dataIdx   <= '0;
      ackValid  <= 1'b0;
      ackBit    <= 1'b0;
      pecErr    <= 1'b0;
    end else begin
      ackValid <= ackFire;
      ackBit   <= ackFire && ackGood;
      if (pecFail)        pecErr <= 1'b1;
      else if (pecErrClr) pecErr <= 1'b0;
      if (busStart) begin
        state     <= ST_ADDR;
        busActive <= 1'b1;
        afterStop <= 1'b0;
      end else if (busStop) begin
        state     <= ST_IDLE;
        busActive <= 1'b0;
        afterStop <= 1'b1;
      end else if (byteDone) begin
        state   <= stateNext;
        dataIdx <= idxNext;
      end
    end
  end

  // R7: a new check error always comes with a NACK
  assert_pec_nack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pecErr) |-> (ackValid && !ackBit));

  // R1/R5: idle or skipping engine gives no decision
  assert_skip_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE || state == ST_SKIP) && !busStart) |=> !ackValid);

  // R3: a decision lasts one clock
  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ackValid |=> !ackValid);

endmodule

// File: rtl/smbus_pec_rx.sv
module smbus_pec_rx
  import smbus_rx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             busStart,
  input  logic             busStop,
  input  logic             bitValid,
  input  logic             bitData,
  input  logic [6:0]       ownAddr,
  input  logic             alertMatchEn,
  input  logic             hostMatchEn,
  input  logic             pecEn,
  input  logic [CNT_W-1:0] dataLen,
  input  logic             countUpEn,
  input  logic             pecErrClr,
  output logic [7:0]       rxData,
  output logic             rxValid,
  output logic             ackValid,
  output logic             ackBit,
  output logic [CNT_W-1:0] byteCount,
  output logic             pecErr
);

  rx_strobe_t        stb;
  logic              lastBit;
  logic [BYTE_W-1:0] byteNext, crcNext;

  smbus_rx_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .busStart(busStart), .busStop(busStop), .bitValid(bitValid),
    .lastBit(lastBit), .byteNext(byteNext), .crcNext(crcNext),
    .ownAddr(ownAddr), .alertMatchEn(alertMatchEn), .hostMatchEn(hostMatchEn),
    .pecEn(pecEn), .dataLen(dataLen), .countUpEn(countUpEn), .pecErrClr(pecErrClr),
    .stb(stb), .ackValid(ackValid), .ackBit(ackBit), .pecErr(pecErr)
  );

  smbus_rx_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .bitData(bitData),
    .lastBit(lastBit), .byteNext(byteNext), .crcNext(crcNext),
    .rxData(rxData), .rxValid(rxValid), .byteCount(byteCount)
  );

  // R4: a delivered byte is always ACKed in the same cycle
  assert_data_acked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |-> (ackValid && ackBit));

endmodule

// File: tb/smbus_pec_rx_tb.sv
module smbus_pec_rx_tb;

  localparam int CNT_W = 8;
  localparam logic [6:0] OWN = 7'h52;
  localparam logic [7:0] OWN_W = {OWN, 1'b0};

  logic clk = 0, rst_n = 0;
  logic busStart = 0, busStop = 0, bitValid = 0, bitData = 0;
  logic alertMatchEn = 0, hostMatchEn = 0, pecEn = 0, countUpEn = 1, pecErrClr = 0;
  logic [CNT_W-1:0] dataLen = '0;
  logic [7:0] rxData;
  logic rxValid, ackValid, ackBit, pecErr;
  logic [CNT_W-1:0] byteCount;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  smbus_pec_rx #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .busStart(busStart), .busStop(busStop),
    .bitValid(bitValid), .bitData(bitData), .ownAddr(OWN),
    .alertMatchEn(alertMatchEn), .hostMatchEn(hostMatchEn), .pecEn(pecEn),
    .dataLen(dataLen), .countUpEn(countUpEn), .pecErrClr(pecErrClr),
    .rxData(rxData), .rxValid(rxValid), .ackValid(ackValid), .ackBit(ackBit),
    .byteCount(byteCount), .pecErr(pecErr)
  );

  function automatic logic [7:0] crcByte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r = c;
    for (int i = 7; i >= 0; i--) begin
      if (r[7] ^ b[i]) r = {r[6:0], 1'b0} ^ 8'h07;
      else             r = {r[6:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk); busStart = 1;
    @(negedge clk); busStart = 0;
  endtask

  task automatic pulseStop();
    @(negedge clk); busStop = 1;
    @(negedge clk); busStop = 0;
  endtask

  // shifts a byte MSB first; returns to a negedge one clock after the 8th strobe
  task automatic sendByte(input logic [7:0] b, output logic av, output logic ab,
                          output logic rv, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); bitValid = 1; bitData = b[i];
      @(negedge clk); bitValid = 0;
      if (i > 0) chk(!ackValid, "R3", ackValid, 0);
    end
    av = ackValid; ab = ackBit; rv = rxValid; rd = rxData;
  endtask

  task automatic expAck(input logic [7:0] b, input logic ack, input logic deliver, input string req);
    logic av, ab, rv;
    logic [7:0] rd;
    sendByte(b, av, ab, rv, rd);
    chk(av == 1'b1 && ab == ack, req, {av, ab}, {1'b1, ack});
    chk(rv == deliver, req, rv, deliver);
    if (deliver) chk(rd == b, req, rd, b);
  endtask

  task automatic expSilent(input logic [7:0] b, input string req);
    logic av, ab, rv;
    logic [7:0] rd;
    sendByte(b, av, ab, rv, rd);
    chk(!av && !rv, req, {av, rv}, 0);
  endtask

  task automatic tReset();
    chk(rxData == 0 && !rxValid && !ackValid && !ackBit, "R11", {rxData, rxValid, ackValid, ackBit}, 0);
    chk(byteCount == 0 && !pecErr, "R11", {byteCount, pecErr}, 0);
  endtask

  task automatic tOwnWrite();
    pecEn = 0; countUpEn = 1;
    pulseStart();
    expAck(OWN_W, 1, 0, "R1");
    expAck(8'h3C, 1, 1, "R4");
    expAck(8'hA5, 1, 1, "R4");
    expAck(8'h00, 1, 1, "R4");
    pulseStop();
    chk(byteCount == 3, "R10", byteCount, 3);
  endtask

  task automatic tMissAndRead();
    pulseStart();
    chk(byteCount == 0, "R10", byteCount, 0);
    expAck(8'h22, 0, 0, "R1");
    expSilent(8'h99, "R1");
    pulseStop();
    pulseStart();
    expAck({OWN, 1'b1}, 0, 0, "R1");
    expSilent(8'h44, "R1");
    pulseStop();
    chk(byteCount == 0, "R10", byteCount, 0);
  endtask

  task automatic tReserved();
    alertMatchEn = 0; hostMatchEn = 0;
    pulseStart(); expAck(8'h18, 0, 0, "R2"); pulseStop();
    pulseStart(); expAck(8'h10, 0, 0, "R2"); pulseStop();
    alertMatchEn = 1;
    pulseStart(); expAck(8'h18, 1, 0, "R2"); pulseStop();
    pulseStart(); expAck(8'h10, 0, 0, "R2"); pulseStop();
    alertMatchEn = 0; hostMatchEn = 1;
    pulseStart(); expAck(8'h10, 1, 0, "R2"); expAck(8'h6E, 1, 1, "R2"); pulseStop();
    hostMatchEn = 0;
  endtask

  task automatic tPecGood();
    logic [7:0] c;
    c = crcByte(crcByte(crcByte(8'h00, OWN_W), 8'h11), 8'hE2);
    pecEn = 1; dataLen = 2; countUpEn = 1;
    pulseStart();
    expAck(OWN_W, 1, 0, "R1");
    expAck(8'h11, 1, 1, "R4");
    expAck(8'hE2, 1, 1, "R4");
    expAck(c, 1, 0, "R6");
    chk(!pecErr, "R6", pecErr, 0);
    expSilent(8'h5D, "R5");
    pulseStop();
    chk(byteCount == 2, "R10", byteCount, 2);
    pecEn = 0;
  endtask

  task automatic tPecBad();
    logic [7:0] c;
    c = crcByte(crcByte(8'h00, OWN_W), 8'h7B) ^ 8'h01;
    pecEn = 1; dataLen = 1;
    pulseStart();
    expAck(OWN_W, 1, 0, "R1");
    expAck(8'h7B, 1, 1, "R4");
    expAck(c, 0, 0, "R7");
    chk(pecErr, "R7", pecErr, 1);
    pulseStop();
    pecEn = 0;
    pulseStart(); expAck(OWN_W, 1, 0, "R1"); pulseStop();
    chk(pecErr, "R7", pecErr, 1);
    @(negedge clk); pecErrClr = 1;
    @(negedge clk); pecErrClr = 0;
    chk(!pecErr, "R7", pecErr, 0);
  endtask

  task automatic tLinked();
    logic [7:0] c;
    c = crcByte(crcByte(crcByte(crcByte(8'h00, OWN_W), 8'h5A), OWN_W), 8'h3C);
    pecEn = 0; countUpEn = 1;
    pulseStart();
    expAck(OWN_W, 1, 0, "R8");
    expAck(8'h5A, 1, 1, "R8");
    pecEn = 1; dataLen = 1;
    pulseStart();
    expAck(OWN_W, 1, 0, "R9");
    expAck(8'h3C, 1, 1, "R9");
    expAck(c, 1, 0, "R8");
    chk(byteCount == 2, "R10", byteCount, 2);
    pulseStop();
    // same check byte after a stop: CRC restarted from zero, so it mismatches
    pulseStart();
    expAck(OWN_W, 1, 0, "R9");
    expAck(8'h3C, 1, 1, "R9");
    expAck(c, 0, 0, "R9");
    pulseStop();
    @(negedge clk); pecErrClr = 1;
    @(negedge clk); pecErrClr = 0;
    // mismatched address segment still feeds the CRC
    c = crcByte(crcByte(crcByte(8'h00, 8'h22), OWN_W), 8'h01);
    pecEn = 1; dataLen = 1;
    pulseStart();
    expAck(8'h22, 0, 0, "R8");
    pulseStart();
    expAck(OWN_W, 1, 0, "R8");
    expAck(8'h01, 1, 1, "R8");
    expAck(c, 1, 0, "R8");
    pulseStop();
    pecEn = 0;
  endtask

  task automatic tCountOff();
    countUpEn = 0;
    pulseStart();
    expAck(OWN_W, 1, 0, "R1");
    expAck(8'h01, 1, 1, "R10");
    expAck(8'h02, 1, 1, "R10");
    pulseStop();
    chk(byteCount == 0, "R10", byteCount, 0);
    countUpEn = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1;
    @(negedge clk);
    tReset();
    tOwnWrite();
    tMissAndRead();
    tReserved();
    tPecGood();
    tPecBad();
    tLinked();
    tCountOff();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule